// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Controller

This block drives and samples sixteen general-purpose pins. Software reaches it through a small memory-mapped register port with 16-bit data. Bit n of every register refers to pin n. Each pin has a direction bit. Output levels are changed through two write-only registers: one raises the pins written as 1, the other lowers them. No read-modify-write is needed, so concurrent software agents cannot lose an update.

Incoming pin levels pass through a two-stage synchroniser. The synchronised levels feed the input-data register and the interrupt logic. A pin's interrupt can be set to one of three kinds:
- level-sensitive, with a selectable polarity;
- edge-sensitive with a rising-edge enable;
- edge-sensitive with a falling-edge enable.

The two edge enables are independent, so a pin can fire on both transitions. An edge event latches a pending bit that stays set until software clears it. A level event simply follows the pin.

A pin reaches the masked-status register only when its enable bit is set and its mask bit is clear. A single interrupt line is the OR of all masked-status bits. The register port has combinational read data and writes on the clock edge. The reset input is asynchronous, and its release is synchronised inside the block.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, these registers read as follows: direction (0x00) 0x0000, output data (0x20) 0x0000, mask (0x28) 0xFFFF, enable (0x2C) 0x0000, masked status (0x30) 0x0000. In the same state `pin_oe`, `pin_out` and `irq` are all 0.
- R2: The direction register at 0x00 drives `pin_oe` bit for bit, where 1 means output, and it reads back as written.
- R3: Writing a 1 into a bit of 0x18 sets that output-latch bit, and writing a 1 into a bit of 0x1C clears it. Bits written as 0 keep their value. 0x20 reads the latch, and `pin_out` equals the latch.
- R4: The input-data register at 0x14 returns `pin_in` delayed by two clock edges. After one edge the old value is still read.
- R5: A pin whose select bit at 0x04 is 1 is level-sensitive. It is active while its synchronised input equals its polarity bit at 0x08, where 1 means active high.
- R6: A pin whose select bit is 0 is edge-sensitive. Its rising-edge enable at 0x0C and falling-edge enable at 0x10 act independently, and with both set the pin fires on either transition.
- R7: An edge event sets a pending bit that is held until a 1 is written to that bit of 0x34. Bits written as 0 there leave pending bits unchanged. A pending bit latches even while the pin is masked or disabled.
- R8: A level-sensitive pin cannot be cleared through 0x34 while its level stays active. It drops as soon as the level goes away.
- R9: The masked status at 0x30 shows a pin only when its enable bit (0x2C) is 1 and its mask bit (0x28) is 0.
- R10: `irq` is high exactly when the masked status is non-zero.
- R11: Reads of 0x18, 0x1C, 0x34 and of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the address |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output latch |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that the bus never writes while the internal reset is still held. The edge-hold property also assumes that `pin_in` can only add pending events and never remove them while every pin is in edge mode.

The stimulus keeps within these assumptions. It starts bus traffic only after the synchronised reset is released. It changes pins and bus signals at the falling clock edge, one pin scenario at a time. It waits enough cycles for the synchroniser and the edge register before it reads back any status.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  // Register byte offsets on the local bus
  localparam int unsigned OFF_DIR  = 'h00;
  localparam int unsigned OFF_SEL  = 'h04;
  localparam int unsigned OFF_POL  = 'h08;
  localparam int unsigned OFF_RISE = 'h0C;
  localparam int unsigned OFF_FALL = 'h10;
  localparam int unsigned OFF_DIN  = 'h14;
  localparam int unsigned OFF_SET  = 'h18;
  localparam int unsigned OFF_CLR  = 'h1C;
  localparam int unsigned OFF_DOUT = 'h20;
  localparam int unsigned OFF_MASK = 'h28;
  localparam int unsigned OFF_ENA  = 'h2C;
  localparam int unsigned OFF_STAT = 'h30;
  localparam int unsigned OFF_ICLR = 'h34;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s,
  input  logic [N-1:0] lvl_sel,
  input  logic [N-1:0] lvl_pol,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] raw
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic prev_q, pend_q, pend_d, evt;

    // Edge event, qualified by the mode and the two enables
    always_comb begin
      evt    = !lvl_sel[g] &&
               ((rise_en[g] &&  pin_s[g] && !prev_q) ||
                (fall_en[g] && !pin_s[g] &&  prev_q));
      pend_d = (pend_q && !clr[g]) || evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= pin_s[g];
        pend_q <= pend_d;
      end
    end

    assign raw[g] = lvl_sel[g] ? (pin_s[g] == lvl_pol[g]) : pend_q;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  input  logic [N-1:0]  pin_in,
  output logic [N-1:0]  pin_out,
  output logic [N-1:0]  pin_oe,
  output logic          irq
);
  logic rst_i;
  logic [N-1:0] dir_q, sel_q, pol_q, rise_q, fall_q, out_q, mask_q, ena_q;
  logic [N-1:0] dir_d, sel_d, pol_d, rise_d, fall_d, out_d, mask_d, ena_d;
  logic [N-1:0] pin_s, raw, stat, clr_bits;
  logic wr, we_dir, we_sel, we_pol, we_rise, we_fall, we_set, we_clr;
  logic we_mask, we_ena, we_iclr;

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i));

  gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i), .d(pin_in), .q(pin_s));

  // Write decode and next-state logic
  always_comb begin
    wr      = bus_sel && bus_wr;
    we_dir  = wr && (bus_addr == AW'(OFF_DIR));
    we_sel  = wr && (bus_addr == AW'(OFF_SEL));
    we_pol  = wr && (bus_addr == AW'(OFF_POL));
    we_rise = wr && (bus_addr == AW'(OFF_RISE));
    we_fall = wr && (bus_addr == AW'(OFF_FALL));
    we_set  = wr && (bus_addr == AW'(OFF_SET));
    we_clr  = wr && (bus_addr == AW'(OFF_CLR));
    we_mask = wr && (bus_addr == AW'(OFF_MASK));
    we_ena  = wr && (bus_addr == AW'(OFF_ENA));
    we_iclr = wr && (bus_addr == AW'(OFF_ICLR));
    dir_d   = bus_wdata;
    sel_d   = bus_wdata;
    pol_d   = bus_wdata;
    rise_d  = bus_wdata;
    fall_d  = bus_wdata;
    mask_d  = bus_wdata;
    ena_d   = bus_wdata;
    out_d   = we_set ? (out_q | bus_wdata) : (out_q & ~bus_wdata);
    clr_bits = we_iclr ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      dir_q  <= '0;
      sel_q  <= '0;
      pol_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      out_q  <= '0;
      mask_q <= '1;
      ena_q  <= '0;
    end else begin
      if (we_dir)            dir_q  <= dir_d;
      if (we_sel)            sel_q  <= sel_d;
      if (we_pol)            pol_q  <= pol_d;
      if (we_rise)           rise_q <= rise_d;
      if (we_fall)           fall_q <= fall_d;
      if (we_set || we_clr)  out_q  <= out_d;
      if (we_mask)           mask_q <= mask_d;
      if (we_ena)            ena_q  <= ena_d;
    end
  end

  gpio_irq_detect #(.N(N)) u_det (
    .clk(clk), .rst_n(rst_i), .pin_s(pin_s), .lvl_sel(sel_q),
    .lvl_pol(pol_q), .rise_en(rise_q), .fall_en(fall_q),
    .clr(clr_bits), .raw(raw));

  assign stat = raw & ena_q & ~mask_q;

  // Read mux; write-only and unmapped offsets read as zero
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        AW'(OFF_DIR):  bus_rdata = dir_q;
        AW'(OFF_SEL):  bus_rdata = sel_q;
        AW'(OFF_POL):  bus_rdata = pol_q;
        AW'(OFF_RISE): bus_rdata = rise_q;
        AW'(OFF_FALL): bus_rdata = fall_q;
        AW'(OFF_DIN):  bus_rdata = pin_s;
        AW'(OFF_DOUT): bus_rdata = out_q;
        AW'(OFF_MASK): bus_rdata = mask_q;
        AW'(OFF_ENA):  bus_rdata = ena_q;
        AW'(OFF_STAT): bus_rdata = stat;
        default:       bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |stat;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_i,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  bus_rdata,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  pin_oe,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  ena_q,
  input logic [N-1:0]  sel_q,
  input logic          irq
);
  AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_sel && bus_wr && bus_addr == AW'(OFF_DIR)) |=> (pin_oe == $past(bus_wdata))); // R2

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_sel && bus_wr && bus_addr == AW'(OFF_SET)) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R3

  AST_CLR_LOWERS: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_sel && bus_wr && bus_addr == AW'(OFF_CLR)) |=> ((pin_out & $past(bus_wdata)) == '0)); // R3

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_i)
    (irq && sel_q == '0 && !(bus_sel && bus_wr)) |=> irq); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    ((ena_q & ~mask_q) == '0) |-> !irq); // R9

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_sel && !bus_wr && (bus_addr == AW'(OFF_SET) || bus_addr == AW'(OFF_CLR) ||
     bus_addr == AW'(OFF_ICLR))) |-> (bus_rdata == '0)); // R11
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_i(rst_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pin_out(pin_out), .pin_oe(pin_oe), .mask_q(mask_q), .ena_q(ena_q),
  .sel_q(sel_q), .irq(irq));

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [15:0] pin_in = '0, pin_out, pin_oe;
  logic        irq;
  int checks = 0, fails = 0;
  logic [15:0] rd;

  always #4 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rdreg(8'h00, rd); check("R1 dir", rd, 16'h0000);
    rdreg(8'h20, rd); check("R1 dout", rd, 16'h0000);
    rdreg(8'h28, rd); check("R1 mask", rd, 16'hFFFF);
    rdreg(8'h2C, rd); check("R1 ena", rd, 16'h0000);
    rdreg(8'h30, rd); check("R1 stat", rd, 16'h0000);
    check("R1 pins", {pin_oe | pin_out}, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_dir;
    wr(8'h00, 16'hA5A5);
    rdreg(8'h00, rd); check("R2 readback", rd, 16'hA5A5);
    check("R2 pin_oe", pin_oe, 16'hA5A5);
  endtask

  task automatic t_out;
    wr(8'h18, 16'h00F0);
    rdreg(8'h20, rd); check("R3 set", rd, 16'h00F0);
    wr(8'h18, 16'h0003);
    rdreg(8'h20, rd); check("R3 set keeps zeros", rd, 16'h00F3);
    wr(8'h1C, 16'h0030);
    rdreg(8'h20, rd); check("R3 clear", rd, 16'h00C3);
    check("R3 pin_out", pin_out, 16'h00C3);
  endtask

  task automatic t_wo_reads;
    rdreg(8'h18, rd); check("R11 set reg", rd, 16'h0000);
    rdreg(8'h1C, rd); check("R11 clr reg", rd, 16'h0000);
    rdreg(8'h34, rd); check("R11 iclr reg", rd, 16'h0000);
    rdreg(8'h24, rd); check("R11 unmapped", rd, 16'h0000);
  endtask

  task automatic t_din;
    @(negedge clk); pin_in = 16'h1234;
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h14;
    #1 check("R4 one edge", bus_rdata, 16'h0000);
    @(negedge clk); #1 check("R4 two edges", bus_rdata, 16'h1234);
    bus_sel = 1'b0;
    set_pins(16'h0000);
  endtask

  task automatic t_gate_rise;
    wr(8'h0C, 16'h0001);
    set_pins(16'h0001);
    rdreg(8'h30, rd); check("R9 masked", rd, 16'h0000);
    check("R10 irq low masked", {15'd0, irq}, 16'h0000);
    wr(8'h28, 16'hFFF0);
    rdreg(8'h30, rd); check("R9 enable off", rd, 16'h0000);
    wr(8'h2C, 16'h000F);
    rdreg(8'h30, rd); check("R7 latched while masked", rd, 16'h0001);
    check("R10 irq high", {15'd0, irq}, 16'h0001);
    wr(8'h34, 16'hFFFE);
    rdreg(8'h30, rd); check("R7 zero bits keep", rd, 16'h0001);
    wr(8'h34, 16'h0001);
    rdreg(8'h30, rd); check("R7 cleared", rd, 16'h0000);
    set_pins(16'h0000);
    rdreg(8'h30, rd); check("R6 rise-only ignores fall", rd, 16'h0000);
  endtask

  task automatic t_fall;
    wr(8'h10, 16'h0002);
    set_pins(16'h0002);
    rdreg(8'h30, rd); check("R6 fall-only ignores rise", rd, 16'h0000);
    set_pins(16'h0000);
    rdreg(8'h30, rd); check("R6 fall", rd, 16'h0002);
    wr(8'h34, 16'h0002);
  endtask

  task automatic t_both;
    wr(8'h0C, 16'h0005);
    wr(8'h10, 16'h0006);
    set_pins(16'h0004);
    rdreg(8'h30, rd); check("R6 both rise", rd, 16'h0004);
    wr(8'h34, 16'h0004);
    set_pins(16'h0000);
    rdreg(8'h30, rd); check("R6 both fall", rd, 16'h0004);
    wr(8'h34, 16'h0004);
    rdreg(8'h30, rd); check("R7 clear after both", rd, 16'h0000);
  endtask

  task automatic t_level;
    wr(8'h08, 16'h0008);
    wr(8'h04, 16'h0008);
    rdreg(8'h30, rd); check("R5 high inactive", rd, 16'h0000);
    set_pins(16'h0008);
    rdreg(8'h30, rd); check("R5 active high", rd, 16'h0008);
    wr(8'h34, 16'h0008);
    rdreg(8'h30, rd); check("R8 not clearable", rd, 16'h0008);
    set_pins(16'h0000);
    rdreg(8'h30, rd); check("R8 drops", rd, 16'h0000);
    wr(8'h08, 16'h0000);
    rdreg(8'h30, rd); check("R5 active low", rd, 16'h0008);
    check("R10 irq level", {15'd0, irq}, 16'h0001);
    set_pins(16'h0008);
    rdreg(8'h30, rd); check("R5 low inactive", rd, 16'h0000);
    check("R10 irq idle", {15'd0, irq}, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir();
    t_out();
    t_wo_reads();
    t_din();
    t_gate_rise();
    t_fall();
    t_both();
    t_level();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule